// File: doc/BRIEF.md
# Serial Audio (I2S) Transmitter with Register Control

The block turns parallel PCM samples into I2S serial audio. From its system clock it derives a bit clock and a word-select clock through a programmable 8-bit divider. It shifts one sample per slot onto each of `PAIRS` serial data lanes, one lane per stereo pair. Samples arrive on a valid/ready stream. Each slot consumes `PAIRS` words, gathered into a small pool before the slot begins.

Software controls the block through an 8-bit register bus. The bus holds an enable bit, a sticky underflow flag, a read-only flag for the fixed 32-bit slot mode, the divider, and one routing register per lane. A routing register chooses which pool entry its lane sends. Samples are 16 or 24 bits, fixed at build time. With `WIDE_SLOT` set, every slot is padded to 32 bit-clock periods.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset, register 0x00 reads 0 except bit 2, the divider at 0x04 reads 1, and the routing register of lane j (at 0x10 + 4·j) reads j+1. The bit clock, word clock, data lanes, ready and underflow outputs are all low.
- R2: The bit clock has a period of 2·D system clock cycles, where D is the value in register 0x04. A write of 0 to register 0x04 is ignored and the previous value is kept.
- R3: A slot lasts SAMPLE_W bit-clock periods, or 32 when WIDE_SLOT is set. SAMPLE_W is 16 or 24. The word clock toggles once per slot: it is low for the left slot and high for the right slot. The first slot after enable is a left slot.
- R4: The first bit-clock period after each word-clock edge carries the last bit of the previous slot. The sample then follows MSB first, starting one bit-clock period after the edge. Slot bits beyond the sample are zero. Data and the word clock change only when the bit clock falls.
- R5: Each slot takes exactly PAIRS accepted stream words. The k-th word accepted for a slot becomes pool entry k-1. Words for a left slot are accepted before words for the following right slot. With default routing, lane j sends pool entry j.
- R6: A routing register value r with 1 ≤ r ≤ PAIRS makes its lane send pool entry r-1. Any other value makes that lane send all zeros. The register reads back the written value.
- R7: If the pool is not full when a slot starts, every lane sends zeros for that slot and the pool is emptied. A sticky underflow flag is set; it shows on `underflow_o` and on bit 1 of register 0x00. Writing 0x00 with bit 1 set clears it.
- R8: While bit 0 of register 0x00 is 0, the bit clock, word clock and data lanes are held low and `s_ready` is low. Re-enabling restarts with a left slot.
- R9: Bit 2 of register 0x00 reads the WIDE_SLOT build setting, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_data | input | SAMPLE_W | Sample word |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word-select clock, low = left |
| sdata_o | output | PAIRS | Serial data, one lane per stereo pair |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The hardest situations to reach are the slot boundary, where a missing pool entry must turn into a zero slot, and the routing registers selecting pool entries out of their natural order. The bench drives several runs from the ports. Each run clears the design by disabling it, programs a divider and a routing pattern, and then enables the core with the stream either always valid or never valid. A bench-side I2S receiver decodes every slot and compares it with sample values computed from the word index. The runs sweep several dividers and cover identity, swapped, zero and out-of-range routing, on a 16-bit two-lane build and a 24-bit single-lane build with 32-bit slots.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_DIV   = 8'h04;
  localparam logic [7:0] OFS_ROUTE = 8'h10;
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_UF   = 1;
  localparam int unsigned CTRL_WIDE = 2;

  function automatic int unsigned slot_len(int unsigned sample_w, bit wide);
    return wide ? 32 : sample_w;
  endfunction
endpackage

// File: rtl/pcm_tx_regs.sv
module pcm_tx_regs
  import pcm_tx_pkg::*;
#(
  parameter int unsigned PAIRS     = 2,
  parameter bit          WIDE_SLOT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic                  uf,
  output logic                  uf_clr,
  output logic                  en,
  output logic [7:0]            div,
  output logic [PAIRS-1:0][7:0] route
);
  logic                  en_q, en_d;
  logic [7:0]            div_q, div_d;
  logic [PAIRS-1:0][7:0] route_q, route_d;

  always_comb begin
    en_d    = en_q;
    div_d   = div_q;
    route_d = route_q;
    uf_clr  = 1'b0;
    if (we) begin
      if (addr == OFS_CTRL) begin
        en_d   = wdata[CTRL_EN];
        uf_clr = wdata[CTRL_UF];
      end
      if (addr == OFS_DIV && wdata != 8'd0) div_d = wdata;
      for (int j = 0; j < PAIRS; j++) begin
        if (addr == OFS_ROUTE + 8'(4 * j)) route_d[j] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= 8'd1;
      for (int j = 0; j < PAIRS; j++) route_q[j] <= 8'(j + 1);
    end else begin
      en_q    <= en_d;
      div_q   <= div_d;
      route_q <= route_d;
    end
  end

  always_comb begin
    rdata = 8'd0;
    if (addr == OFS_CTRL) begin
      rdata[CTRL_EN]   = en_q;
      rdata[CTRL_UF]   = uf;
      rdata[CTRL_WIDE] = WIDE_SLOT;
    end
    if (addr == OFS_DIV) rdata = div_q;
    for (int j = 0; j < PAIRS; j++) begin
      if (addr == OFS_ROUTE + 8'(4 * j)) rdata = route_q[j];
    end
  end

  assign en    = en_q;
  assign div   = div_q;
  assign route = route_q;

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    div_q != 8'd0); // R2
endmodule

// File: rtl/pcm_tx_clkdiv.sv
module pcm_tx_clkdiv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] div,
  output logic       sclk,
  output logic       fall_stb
);
  logic [7:0] cnt_q, cnt_d;
  logic       sclk_q, sclk_d;
  logic       tick;

  assign tick     = en && (cnt_q >= div - 8'd1);
  assign fall_stb = tick && sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = 8'd0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = 8'd0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 8'd0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk_q); // R8
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer #(
  parameter int unsigned SLOT = 16,
  localparam int unsigned POS_W = $clog2(SLOT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fall_stb,
  output logic lrclk,
  output logic slot_load
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             lr_q, lr_d;

  assign slot_load = fall_stb && (pos_q == POS_W'(SLOT - 1));

  always_comb begin
    pos_d = pos_q;
    lr_d  = lr_q;
    if (!en) begin
      pos_d = POS_W'(SLOT - 1);
      lr_d  = 1'b0;
    end else if (fall_stb) begin
      pos_d = (pos_q == POS_W'(SLOT - 1)) ? '0 : pos_q + POS_W'(1);
      if (pos_q == POS_W'(SLOT - 2)) lr_d = ~lr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_W'(SLOT - 1);
      lr_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      lr_q  <= lr_d;
    end
  end

  assign lrclk = lr_q;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int unsigned PAIRS    = 2,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SLOT     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         fall_stb,
  input  logic                         load,
  input  logic                         load_ok,
  input  logic [PAIRS-1:0][SAMPLE_W-1:0] pool,
  input  logic [7:0]                   route,
  output logic                         sdata
);
  logic [SAMPLE_W-1:0] word;
  logic [SLOT-1:0]     sh_q, sh_d;

  always_comb begin
    word = '0;
    for (int k = 0; k < PAIRS; k++) begin
      if (route == 8'(k + 1)) word = pool[k];
    end
  end

  always_comb begin
    sh_d = sh_q;
    if (!en)           sh_d = '0;
    else if (load)     sh_d = load_ok ? (SLOT'(word) << (SLOT - SAMPLE_W)) : '0;
    else if (fall_stb) sh_d = {sh_q[SLOT-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sdata = sh_q[SLOT-1];
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int unsigned PAIRS     = 2,
  parameter int unsigned SAMPLE_W  = 16,
  parameter bit          WIDE_SLOT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                sclk_o,
  output logic                lrclk_o,
  output logic [PAIRS-1:0]    sdata_o,
  output logic                underflow_o
);
  localparam int unsigned SLOT  = slot_len(SAMPLE_W, WIDE_SLOT);
  localparam int unsigned CNT_W = $clog2(PAIRS + 1);

  if (!(SAMPLE_W == 16 || SAMPLE_W == 24)) begin : g_bad_width
    $error("SAMPLE_W must be 16 or 24");
  end

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                           en, uf_clr, fall_stb, slot_load, full;
  logic [7:0]                     div;
  logic [PAIRS-1:0][7:0]          route;
  logic [PAIRS-1:0][SAMPLE_W-1:0] pool_q, pool_d;
  logic [CNT_W-1:0]               fill_q, fill_d;
  logic                           uf_q, uf_d;

  pcm_tx_regs #(.PAIRS(PAIRS), .WIDE_SLOT(WIDE_SLOT)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .uf(uf_q), .uf_clr(uf_clr),
    .en(en), .div(div), .route(route)
  );

  pcm_tx_clkdiv u_div (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .div(div),
    .sclk(sclk_o), .fall_stb(fall_stb)
  );

  pcm_tx_framer #(.SLOT(SLOT)) u_frame (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .fall_stb(fall_stb),
    .lrclk(lrclk_o), .slot_load(slot_load)
  );

  for (genvar j = 0; j < PAIRS; j++) begin : g_lane
    pcm_tx_lane #(.PAIRS(PAIRS), .SAMPLE_W(SAMPLE_W), .SLOT(SLOT)) u_lane (
      .clk(clk), .rst_n(rst_sync_n), .en(en), .fall_stb(fall_stb),
      .load(slot_load), .load_ok(full), .pool(pool_q), .route(route[j]),
      .sdata(sdata_o[j])
    );
  end

  assign full    = (fill_q == CNT_W'(PAIRS));
  assign s_ready = en && !full && !slot_load;

  always_comb begin
    pool_d = pool_q;
    fill_d = fill_q;
    uf_d   = (uf_q && !uf_clr) || (slot_load && !full);
    if (!en || slot_load) begin
      fill_d = '0;
    end else if (s_valid && s_ready) begin
      for (int k = 0; k < PAIRS; k++) begin
        if (fill_q == CNT_W'(k)) pool_d[k] = s_data;
      end
      fill_d = fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pool_q <= '0;
      fill_q <= '0;
      uf_q   <= 1'b0;
    end else begin
      pool_q <= pool_d;
      fill_q <= fill_d;
      uf_q   <= uf_d;
    end
  end

  assign underflow_o = uf_q;

  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lrclk_o != $past(lrclk_o)) |-> (($past(sclk_o) && !sclk_o) || !en)); // R4
  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sdata_o != $past(sdata_o)) |-> (($past(sclk_o) && !sclk_o) || !en)); // R4
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(uf_q) && !$past(uf_clr)) |-> uf_q); // R7
  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_q <= CNT_W'(PAIRS)); // R5
endmodule

// File: tb/pcm_serial_tx_tb.sv
module pcm_serial_tx_mon #(
  parameter int unsigned LANES = 2,
  parameter int unsigned SLOT  = 16
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       sclk,
  input  logic                       lrclk,
  input  logic [LANES-1:0]           sdata,
  output logic                       stb,
  output logic                       word_lr,
  output logic [LANES-1:0][SLOT-1:0] word,
  output int                         nbits,
  output int                         gap
);
  logic [LANES-1:0][SLOT-1:0] sh, nxt;
  logic sclk_p, lr_p;
  int   cyc, last_rise, cnt;

  initial begin
    stb = 0; word_lr = 0; word = '0; nbits = 0; gap = 0;
    sh = '0; sclk_p = 0; lr_p = 0; cyc = 0; last_rise = 0; cnt = 0;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    stb <= 1'b0;
    if (clr) begin
      sh = '0; sclk_p = 0; lr_p = 0; cnt = 0;
    end else begin
      if (sclk && !sclk_p) begin
        gap <= cyc - last_rise;
        last_rise = cyc;
        for (int l = 0; l < LANES; l++) nxt[l] = {sh[l][SLOT-2:0], sdata[l]};
        cnt = cnt + 1;
        if (lrclk != lr_p) begin
          word    <= nxt;
          word_lr <= lr_p;
          nbits   <= cnt;
          stb     <= 1'b1;
          cnt = 0;
        end
        sh = nxt;
        lr_p = lrclk;
      end
      sclk_p = sclk;
    end
  end
endmodule

module pcm_serial_tx_tb;
  localparam logic [7:0] A_CTRL = 8'h00, A_DIV = 8'h04, A_RT0 = 8'h10, A_RT1 = 8'h14;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [1:0] we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata0, rdata1;

  logic        v0 = 0, rdy0, sclk0, lr0, uf0, fclr0 = 0, mclr0 = 0;
  logic [15:0] d0;
  logic [1:0]  sd0;
  int          idx0;
  logic        v1 = 0, rdy1, sclk1, lr1, uf1, fclr1 = 0, mclr1 = 0;
  logic [23:0] d1;
  logic [0:0]  sd1;
  int          idx1;

  function automatic logic [15:0] f16(int n);
    int t = n * 977 + 4660;
    return t[15:0];
  endfunction
  function automatic logic [23:0] f24(int n);
    int t = n * 40503 + 1193046;
    return t[23:0];
  endfunction

  assign d0 = f16(idx0);
  assign d1 = f24(idx1);

  always @(posedge clk) begin
    if (fclr0) idx0 <= 0; else if (v0 && rdy0) idx0 <= idx0 + 1;
    if (fclr1) idx1 <= 0; else if (v1 && rdy1) idx1 <= idx1 + 1;
  end

  pcm_serial_tx #(.PAIRS(2), .SAMPLE_W(16), .WIDE_SLOT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we[0]), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata0), .s_valid(v0), .s_ready(rdy0), .s_data(d0),
    .sclk_o(sclk0), .lrclk_o(lr0), .sdata_o(sd0), .underflow_o(uf0));

  pcm_serial_tx #(.PAIRS(1), .SAMPLE_W(24), .WIDE_SLOT(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .reg_we(we[1]), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata1), .s_valid(v1), .s_ready(rdy1), .s_data(d1),
    .sclk_o(sclk1), .lrclk_o(lr1), .sdata_o(sd1), .underflow_o(uf1));

  logic             m0_stb, m0_lr, m1_stb, m1_lr;
  logic [1:0][15:0] m0_w;
  logic [0:0][31:0] m1_w;
  int               m0_bits, m0_gap, m1_bits, m1_gap;

  pcm_serial_tx_mon #(.LANES(2), .SLOT(16)) u_mon0 (
    .clk(clk), .clr(mclr0), .sclk(sclk0), .lrclk(lr0), .sdata(sd0),
    .stb(m0_stb), .word_lr(m0_lr), .word(m0_w), .nbits(m0_bits), .gap(m0_gap));
  pcm_serial_tx_mon #(.LANES(1), .SLOT(32)) u_mon1 (
    .clk(clk), .clr(mclr1), .sclk(sclk1), .lrclk(lr1), .sdata(sd1),
    .stb(m1_stb), .word_lr(m1_lr), .word(m1_w), .nbits(m1_bits), .gap(m1_gap));

  // expectations of the running test
  bit    act0 = 0, feed0 = 0, act1 = 0;
  int    div0 = 1, div1 = 1, slot0 = 0, slot1 = 0;
  int    rt[2] = '{1, 2};
  string req0 = "R5";

  function automatic logic [15:0] exp0(int s, int l);
    if (!feed0 || rt[l] < 1 || rt[l] > 2) return 16'h0;
    return f16(s * 2 + rt[l] - 1);
  endfunction

  always @(posedge clk) begin
    if (act0 && m0_stb) begin
      check(m0_lr == slot0[0], "R3", "word clock level of slot", 32'(m0_lr), 32'(slot0[0]));
      for (int l = 0; l < 2; l++)
        check(m0_w[l] == exp0(slot0, l), req0, "lane word", 32'(m0_w[l]), 32'(exp0(slot0, l)));
      if (slot0 > 0) check(m0_bits == 16, "R3", "bit clocks per slot", 32'(m0_bits), 32'd16);
      check(m0_gap == 2 * div0, "R2", "bit clock period", 32'(m0_gap), 32'(2 * div0));
      if (!feed0) check(uf0 == 1'b1, "R7", "underflow flag during starved run", 32'(uf0), 32'd1);
      slot0++;
    end
    if (act1 && m1_stb) begin
      check(m1_lr == slot1[0], "R3", "wide word clock level", 32'(m1_lr), 32'(slot1[0]));
      check(m1_w[0] == {f24(slot1), 8'h00}, "R4", "padded wide word", m1_w[0], {f24(slot1), 8'h00});
      if (slot1 > 0) check(m1_bits == 32, "R3", "wide bit clocks per slot", 32'(m1_bits), 32'd32);
      check(m1_gap == 2 * div1, "R2", "wide bit clock period", 32'(m1_gap), 32'(2 * div1));
      slot1++;
    end
  end

  task automatic wr(int w, logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we[w] = 1'b1;
    @(posedge clk); #1;
    we = 2'b00;
  endtask

  task automatic rd(int w, logic [7:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    addr = a;
    #2;
    d = (w == 1) ? rdata1 : rdata0;
  endtask

  task automatic idle_check0(string tag);
    repeat (4) @(posedge clk);
    #1;
    check({sclk0, lr0, sd0, rdy0} == 5'b0, "R8", tag, 32'({sclk0, lr0, sd0, rdy0}), 32'd0);
  endtask

  task automatic run0(int dv, int r0, int r1, bit feed, string req);
    wr(0, A_CTRL, 8'h00);
    repeat (4) @(posedge clk);
    wr(0, A_DIV, 8'(dv)); wr(0, A_RT0, 8'(r0)); wr(0, A_RT1, 8'(r1));
    @(posedge clk); #1;
    fclr0 = 1; mclr0 = 1; v0 = feed;
    div0 = dv; rt[0] = r0; rt[1] = r1; feed0 = feed; req0 = req; slot0 = 0;
    @(posedge clk); #1;
    fclr0 = 0; mclr0 = 0; act0 = 1;
    wr(0, A_CTRL, 8'h01);
    repeat (8 * 2 * dv * 16 + 40) @(posedge clk);
    act0 = 0;
    check(slot0 >= 6, "R3", "slots decoded in run", 32'(slot0), 32'd6);
    wr(0, A_CTRL, 8'h00);
    v0 = 0;
    idle_check0("outputs idle after disable");
  endtask

  task automatic run1(int dv);
    wr(1, A_CTRL, 8'h00);
    repeat (4) @(posedge clk);
    wr(1, A_DIV, 8'(dv));
    @(posedge clk); #1;
    fclr1 = 1; mclr1 = 1; v1 = 1; div1 = dv; slot1 = 0;
    @(posedge clk); #1;
    fclr1 = 0; mclr1 = 0; act1 = 1;
    wr(1, A_CTRL, 8'h01);
    repeat (7 * 2 * dv * 32 + 40) @(posedge clk);
    act1 = 0;
    check(slot1 >= 5, "R3", "wide slots decoded", 32'(slot1), 32'd5);
    wr(1, A_CTRL, 8'h00);
    v1 = 0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check({sclk0, lr0, sd0, rdy0, uf0} == 6'b0, "R1", "outputs after reset",
          32'({sclk0, lr0, sd0, rdy0, uf0}), 32'd0);
    rd(0, A_CTRL, r); check(r == 8'h00, "R1", "control reset", 32'(r), 32'h00);
    rd(0, A_DIV, r);  check(r == 8'h01, "R1", "divider reset", 32'(r), 32'h01);
    rd(0, A_RT0, r);  check(r == 8'h01, "R1", "route lane0 reset", 32'(r), 32'h01);
    rd(0, A_RT1, r);  check(r == 8'h02, "R1", "route lane1 reset", 32'(r), 32'h02);
    rd(1, A_CTRL, r); check(r == 8'h04, "R9", "wide flag read", 32'(r), 32'h04);
    // R9 write attempt to the read-only flag
    wr(0, A_CTRL, 8'h04); rd(0, A_CTRL, r);
    check(r == 8'h00, "R9", "wide flag not writable", 32'(r), 32'h00);
    wr(1, A_CTRL, 8'h00); rd(1, A_CTRL, r);
    check(r == 8'h04, "R9", "wide flag not clearable", 32'(r), 32'h04);
    // R2 zero divider ignored
    wr(0, A_DIV, 8'd3); wr(0, A_DIV, 8'd0); rd(0, A_DIV, r);
    check(r == 8'd3, "R2", "zero divider ignored", 32'(r), 32'd3);
    // R4 R5 identity routing across dividers
    for (int dv = 2; dv <= 5; dv++) run0(dv, 1, 2, 1'b1, "R5");
    check(uf0 == 1'b0, "R7", "no underflow while fed", 32'(uf0), 32'd0);
    // R6 routing variants
    run0(2, 2, 1, 1'b1, "R6");
    rd(0, A_RT0, r); check(r == 8'd2, "R6", "route readback", 32'(r), 32'd2);
    run0(3, 0, 3, 1'b1, "R6");
    run0(2, 2, 2, 1'b1, "R6");
    // R7 starved run
    run0(2, 1, 2, 1'b0, "R7");
    rd(0, A_CTRL, r); check(r[1] == 1'b1, "R7", "underflow bit held", 32'(r), 32'h02);
    wr(0, A_CTRL, 8'h02);
    rd(0, A_CTRL, r); check(r == 8'h00, "R7", "underflow cleared", 32'(r), 32'h00);
    #1 check(uf0 == 1'b0, "R7", "underflow port cleared", 32'(uf0), 32'd0);
    // R8 restart after starved run resumes at a left slot with correct data
    run0(4, 1, 2, 1'b1, "R8");
    // R3 R4 wide slot build
    for (int dv = 1; dv <= 3; dv++) run1(dv);
    finish_up();
  end
endmodule